// File: doc/BRIEF.md
# Quad Serial DAC Write Controller

This block is the host side of a serial link to a four-channel, 12-bit voltage-output converter. A command carries a 2-bit channel number and a 12-bit code and is taken through a valid/ready handshake. The block turns each command into one 16-bit serial frame on a clock, data and active-low select line. It then closes the frame on the select line and fires an active-low load strobe, which moves the received word into the addressed channel.

On the receiving side, select and serial clock pass through one OR gate. For that reason the sequencer moves select only while the serial clock is high, so no spurious shift edge can appear. A separate single-cycle clear request drives the active-low clear line and the clear-select line. A clear that arrives in the same cycle as a command is carried out first. A clear that arrives during a frame waits until that frame's load strobe has finished.

The serial clock half-period, the select-to-first-edge setup, the load pulse width and the clear pulse width are parameters, each counted in system-clock cycles.

Top module: `quad_dac_link`

## Requirements
- R1: Each frame carries the word {chan[1:0], 2'b00, code[11:0]}, bit 15 first and bit 0 last. The receiver captures sdi at each rising edge of (sclk OR csn).
- R2: Between frames sclk rests high. Inside a frame, sdi changes only in the cycle where sclk falls, so sdi stays steady through every high phase.
- R3: Between the fall of csn and the following load strobe there are exactly 16 rising edges of (sclk OR csn).
- R4: csn falls only while sclk is high. csn rises only while sclk is high and sclk was also high in the cycle before. sclk is never low while csn is high.
- R5: Every low phase and every high phase of sclk inside a frame lasts HALF_CYC cycles. csn is low for SETUP_CYC cycles before sclk first falls.
- R6: After csn rises, ldn goes low for exactly LOAD_CYC cycles, only while csn is high. ldn is back high before the next frame lowers csn.
- R7: A clear drives clrn low for exactly CLR_CYC cycles. During that pulse clrsel holds the requested select (1 = midscale code 0x800, 0 = zero code 0x000) and does not change, while csn and ldn stay high.
- R8: cmd_ready is high only when the link is idle, with sclk, csn, ldn and clrn all high. Each accepted command produces exactly one frame, in acceptance order. A valid held while cmd_ready is low waits and is not lost.
- R9: When clr_req and a command handshake fall in the same cycle, the clear pulse is issued before that command's frame.
- R10: After reset, sclk, csn, ldn and clrn are high, clrsel is low and cmd_ready is high.
- R11: A clear requested while a frame is in flight is held until that frame's load strobe ends. The frame itself is delivered unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command can be taken this cycle |
| cmd_chan | input | 2 | Target channel number |
| cmd_code | input | 12 | Code for the target channel |
| clr_req | input | 1 | Single-cycle clear request |
| clr_mid | input | 1 | Clear target: 1 midscale, 0 zero scale |
| dac_sclk | output | 1 | Serial clock, idles high |
| dac_sdi | output | 1 | Serial data, MSB first |
| dac_csn | output | 1 | Active-low frame select |
| dac_ldn | output | 1 | Active-low load strobe |
| dac_clrn | output | 1 | Active-low clear pulse |
| dac_clrsel | output | 1 | Clear target select |

## Verification
Two functions can land in the same cycle: a clear request and a command handshake. The bench provokes this by raising clr_req in the very cycle a command is accepted while the link is idle, both in a directed case and in a share of the random operations. It also fires clears in the middle of frames. Every clear and every accepted command is logged into one expected-event queue in arrival order, with the clear placed first on a tie. Each observed clear pulse and each observed load strobe must then match the head of that queue in kind, select and received word.

// File: rtl/qdl_pkg.sv
`timescale 1ns/1ps
package qdl_pkg;
    localparam int CHAN_W   = 2;
    localparam int CODE_W   = 12;
    localparam int PAD_W    = 2;
    localparam int FRAME_W  = CHAN_W + PAD_W + CODE_W;
    localparam int BITCNT_W = $clog2(FRAME_W);

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_SETUP,
        SQ_LOW,
        SQ_HIGH,
        SQ_CSUP,
        SQ_LOAD,
        SQ_CLRSET,
        SQ_CLR
    } seq_state_e;

    typedef struct packed {
        logic sclk;
        logic csn;
        logic ldn;
        logic clrn;
    } pins_t;

    typedef struct packed {
        logic [CHAN_W-1:0] chan;
        logic [CODE_W-1:0] code;
    } cmd_t;

    function automatic logic [FRAME_W-1:0] pack_frame(cmd_t c);
        return {c.chan, {PAD_W{1'b0}}, c.code};
    endfunction

    function automatic pins_t pins_for(seq_state_e s);
        pins_t p;
        p.sclk = (s != SQ_LOW);
        p.csn  = !((s == SQ_SETUP) || (s == SQ_LOW) || (s == SQ_HIGH));
        p.ldn  = (s != SQ_LOAD);
        p.clrn = (s != SQ_CLR);
        return p;
    endfunction

    function automatic int max4(int a, int b, int c, int d);
        int m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction
endpackage

// File: rtl/qdl_timer.sv
`timescale 1ns/1ps
module qdl_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             done
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign done = (cnt_q == '0);
endmodule

// File: rtl/qdl_shifter.sv
`timescale 1ns/1ps
module qdl_shifter #(
    parameter int W    = 16,
    parameter int BC_W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_word,
    input  logic         shift,
    input  logic         restart,
    output logic         msb,
    output logic         last
);
    logic [W-1:0]    sh_q;
    logic [BC_W-1:0] bit_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q <= '0;
        end else if (load) begin
            sh_q <= load_word;
        end else if (shift) begin
            sh_q <= {sh_q[W-2:0], 1'b0};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bit_q <= '0;
        end else if (restart) begin
            bit_q <= '0;
        end else if (shift) begin
            bit_q <= bit_q + 1'b1;
        end
    end

    assign msb  = sh_q[W-1];
    assign last = (bit_q == BC_W'(W-1));
endmodule

// File: rtl/qdl_seq.sv
`timescale 1ns/1ps
module qdl_seq
    import qdl_pkg::*;
#(
    parameter int HALF_CYC  = 4,
    parameter int SETUP_CYC = 4,
    parameter int LOAD_CYC  = 4,
    parameter int CLR_CYC   = 8,
    parameter int CNT_W     = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tmr_done,
    input  logic             clr_pend,
    input  logic             word_pend,
    input  logic             last_bit,
    output seq_state_e       state_q,
    output pins_t            pins_q,
    output logic             tmr_load,
    output logic [CNT_W-1:0] tmr_val,
    output logic             shift_en,
    output logic             frame_go,
    output logic             clear_go
);
    seq_state_e state_n;

    always_comb begin
        state_n = state_q;
        case (state_q)
            SQ_IDLE: begin
                if (clr_pend)       state_n = SQ_CLRSET;
                else if (word_pend) state_n = SQ_SETUP;
            end
            SQ_SETUP:  if (tmr_done) state_n = SQ_LOW;
            SQ_LOW:    if (tmr_done) state_n = SQ_HIGH;
            SQ_HIGH:   if (tmr_done) state_n = last_bit ? SQ_CSUP : SQ_LOW;
            SQ_CSUP:   if (tmr_done) state_n = SQ_LOAD;
            SQ_LOAD:   if (tmr_done) state_n = SQ_IDLE;
            SQ_CLRSET: if (tmr_done) state_n = SQ_CLR;
            SQ_CLR:    if (tmr_done) state_n = SQ_IDLE;
            default:   state_n = SQ_IDLE;
        endcase
    end

    always_comb begin
        case (state_n)
            SQ_SETUP: tmr_val = CNT_W'(SETUP_CYC - 1);
            SQ_LOW,
            SQ_HIGH,
            SQ_CSUP:  tmr_val = CNT_W'(HALF_CYC - 1);
            SQ_LOAD:  tmr_val = CNT_W'(LOAD_CYC - 1);
            SQ_CLR:   tmr_val = CNT_W'(CLR_CYC - 1);
            default:  tmr_val = '0;
        endcase
    end

    assign tmr_load = (state_n != state_q);
    assign shift_en = (state_q == SQ_HIGH) && (state_n == SQ_LOW);
    assign frame_go = (state_q == SQ_IDLE) && (state_n == SQ_SETUP);
    assign clear_go = (state_q == SQ_IDLE) && (state_n == SQ_CLRSET);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SQ_IDLE;
            pins_q  <= pins_for(SQ_IDLE);
        end else begin
            state_q <= state_n;
            pins_q  <= pins_for(state_n);
        end
    end
endmodule

// File: rtl/quad_dac_link.sv
`timescale 1ns/1ps
module quad_dac_link
    import qdl_pkg::*;
#(
    parameter int HALF_CYC  = 4,
    parameter int SETUP_CYC = 4,
    parameter int LOAD_CYC  = 4,
    parameter int CLR_CYC   = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [CHAN_W-1:0] cmd_chan,
    input  logic [CODE_W-1:0] cmd_code,
    input  logic              clr_req,
    input  logic              clr_mid,
    output logic              dac_sclk,
    output logic              dac_sdi,
    output logic              dac_csn,
    output logic              dac_ldn,
    output logic              dac_clrn,
    output logic              dac_clrsel
);
    localparam int CNT_MAX = max4(HALF_CYC, SETUP_CYC, LOAD_CYC, CLR_CYC);
    localparam int CNT_W   = $clog2(CNT_MAX + 1);

    seq_state_e       state_q;
    pins_t            pins_q;
    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_done;
    logic             shift_en;
    logic             frame_go;
    logic             clear_go;
    logic             last_bit;
    logic             word_pend_q;
    logic             clr_pend_q;
    logic             pend_sel_q;
    logic             clrsel_q;
    logic             accept;
    cmd_t             cmd_in;

    assign cmd_in    = '{chan: cmd_chan, code: cmd_code};
    assign cmd_ready = (state_q == SQ_IDLE) && !word_pend_q;
    assign accept    = cmd_valid && cmd_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            word_pend_q <= 1'b0;
        end else if (accept) begin
            word_pend_q <= 1'b1;
        end else if (frame_go) begin
            word_pend_q <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            clr_pend_q <= 1'b0;
            pend_sel_q <= 1'b0;
        end else if (clr_req) begin
            clr_pend_q <= 1'b1;
            pend_sel_q <= clr_mid;
        end else if (clear_go) begin
            clr_pend_q <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            clrsel_q <= 1'b0;
        end else if (clear_go) begin
            clrsel_q <= pend_sel_q;
        end
    end

    qdl_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .done     (tmr_done)
    );

    qdl_shifter #(.W(FRAME_W), .BC_W(BITCNT_W)) u_shift (
        .clk       (clk),
        .rst       (rst),
        .load      (accept),
        .load_word (pack_frame(cmd_in)),
        .shift     (shift_en),
        .restart   (frame_go),
        .msb       (dac_sdi),
        .last      (last_bit)
    );

    qdl_seq #(
        .HALF_CYC  (HALF_CYC),
        .SETUP_CYC (SETUP_CYC),
        .LOAD_CYC  (LOAD_CYC),
        .CLR_CYC   (CLR_CYC),
        .CNT_W     (CNT_W)
    ) u_seq (
        .clk       (clk),
        .rst       (rst),
        .tmr_done  (tmr_done),
        .clr_pend  (clr_pend_q),
        .word_pend (word_pend_q),
        .last_bit  (last_bit),
        .state_q   (state_q),
        .pins_q    (pins_q),
        .tmr_load  (tmr_load),
        .tmr_val   (tmr_val),
        .shift_en  (shift_en),
        .frame_go  (frame_go),
        .clear_go  (clear_go)
    );

    assign dac_sclk   = pins_q.sclk;
    assign dac_csn    = pins_q.csn;
    assign dac_ldn    = pins_q.ldn;
    assign dac_clrn   = pins_q.clrn;
    assign dac_clrsel = clrsel_q;
endmodule

// File: rtl/qdl_checker.sv
`timescale 1ns/1ps
module qdl_checker (
    input logic clk,
    input logic rst,
    input logic cmd_ready,
    input logic dac_sclk,
    input logic dac_sdi,
    input logic dac_csn,
    input logic dac_ldn,
    input logic dac_clrn,
    input logic dac_clrsel
);
    p_cs_fall_hi_r4: assert property (@(posedge clk) disable iff (rst)
        $fell(dac_csn) |-> dac_sclk);

    p_cs_rise_hi_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(dac_csn) |-> (dac_sclk && $past(dac_sclk)));

    p_sclk_low_sel_r4: assert property (@(posedge clk) disable iff (rst)
        !dac_sclk |-> !dac_csn);

    p_sdi_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (!dac_csn && $past(!dac_csn) && dac_sclk && $past(dac_sclk)) |-> $stable(dac_sdi));

    p_ld_cs_hi_r6: assert property (@(posedge clk) disable iff (rst)
        !dac_ldn |-> dac_csn);

    p_clrsel_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (!dac_clrn && $past(!dac_clrn)) |-> $stable(dac_clrsel));

    p_clr_quiet_r7: assert property (@(posedge clk) disable iff (rst)
        !dac_clrn |-> (dac_csn && dac_ldn && dac_sclk));

    p_ready_idle_r8: assert property (@(posedge clk) disable iff (rst)
        cmd_ready |-> (dac_csn && dac_ldn && dac_clrn && dac_sclk));
endmodule

bind quad_dac_link qdl_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .cmd_ready  (cmd_ready),
    .dac_sclk   (dac_sclk),
    .dac_sdi    (dac_sdi),
    .dac_csn    (dac_csn),
    .dac_ldn    (dac_ldn),
    .dac_clrn   (dac_clrn),
    .dac_clrsel (dac_clrsel)
);

// File: tb/quad_dac_link_tb.sv
`timescale 1ns/1ps
module quad_dac_link_tb;
    localparam int HALF  = 2;
    localparam int SETUP = 3;
    localparam int LOADW = 3;
    localparam int CLRW  = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_valid = 1'b0;
    logic        cmd_ready;
    logic [1:0]  cmd_chan = '0;
    logic [11:0] cmd_code = '0;
    logic        clr_req = 1'b0;
    logic        clr_mid = 1'b0;
    logic        dac_sclk, dac_sdi, dac_csn, dac_ldn, dac_clrn, dac_clrsel;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    quad_dac_link #(
        .HALF_CYC(HALF), .SETUP_CYC(SETUP), .LOAD_CYC(LOADW), .CLR_CYC(CLRW)
    ) u_dut (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_chan(cmd_chan), .cmd_code(cmd_code), .clr_req(clr_req), .clr_mid(clr_mid),
        .dac_sclk(dac_sclk), .dac_sdi(dac_sdi), .dac_csn(dac_csn), .dac_ldn(dac_ldn),
        .dac_clrn(dac_clrn), .dac_clrsel(dac_clrsel)
    );

    function automatic logic [15:0] exp_word(logic [1:0] ch, logic [11:0] cd);
        return {ch, 2'b00, cd};
    endfunction

    task automatic chk(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // expected events: [17] clear, [16] select, [15:0] word
    logic [17:0] evq[$];
    logic [17:0] ev;
    logic        p_sclk, p_csn, p_ldn, p_clrn, p_sdi;
    logic [15:0] rx;
    int          nbits, setup_cnt, lo_cnt, hi_cnt, ld_cnt, clr_cnt;
    bit          in_setup, phase_bad, sdi_bad, sel_bad;
    logic        sel_ref;

    always @(negedge clk) begin
        if (rst) begin
            p_sclk <= dac_sclk; p_csn <= dac_csn; p_ldn <= dac_ldn;
            p_clrn <= dac_clrn; p_sdi <= dac_sdi;
        end else begin
            if (clr_req) evq.push_back({1'b1, clr_mid, 16'h0});
            if (cmd_valid && cmd_ready) evq.push_back({2'b00, exp_word(cmd_chan, cmd_code)});

            if (p_csn && !dac_csn) begin
                chk(dac_sclk, "R4", "csn fell with sclk low", dac_sclk, 1);
                nbits = 0; in_setup = 1; setup_cnt = 0; lo_cnt = 0; hi_cnt = 0;
                phase_bad = 0; sdi_bad = 0;
            end
            if (!(p_sclk | p_csn) && (dac_sclk | dac_csn)) begin
                rx = {rx[14:0], dac_sdi};
                nbits++;
            end
            if (p_sclk && !dac_sclk && !dac_csn) begin
                if (in_setup) begin
                    if (setup_cnt != SETUP) phase_bad = 1;
                    in_setup = 0;
                end else if (hi_cnt != HALF) phase_bad = 1;
                hi_cnt = 0;
            end
            if (!p_sclk && dac_sclk && !dac_csn) begin
                if (lo_cnt != HALF) phase_bad = 1;
                lo_cnt = 0;
            end
            if (!dac_csn) begin
                if (dac_sclk) begin
                    if (in_setup) setup_cnt++;
                    else hi_cnt++;
                end else lo_cnt++;
            end
            if (!dac_csn && !p_csn && dac_sclk && p_sclk && (dac_sdi != p_sdi)) sdi_bad = 1;
            if (!p_csn && dac_csn) begin
                chk(dac_sclk && p_sclk, "R4", "csn rose without sclk high", {p_sclk, dac_sclk}, 3);
                if (hi_cnt != HALF) phase_bad = 1;
            end

            if (p_ldn && !dac_ldn) begin
                if (evq.size() == 0) chk(0, "R8", "load strobe with no command", 1, 0);
                else begin
                    ev = evq.pop_front();
                    chk(ev[17] == 1'b0, "R9 R11", "event order: frame where clear expected", ev[17], 1);
                    chk(rx == ev[15:0], "R1", "received word", rx, ev[15:0]);
                end
                chk(nbits == 16, "R3", "rising edges per frame", nbits, 16);
                chk(!phase_bad, "R5", "sclk phase or setup length", phase_bad, 0);
                chk(!sdi_bad, "R2", "sdi moved while sclk high", sdi_bad, 0);
                chk(dac_csn, "R6", "load strobe while csn low", dac_csn, 1);
                chk(!cmd_ready, "R8", "ready during load", cmd_ready, 0);
                ld_cnt = 0;
            end
            if (!dac_ldn) ld_cnt++;
            if (!p_ldn && dac_ldn) chk(ld_cnt == LOADW, "R6", "load pulse width", ld_cnt, LOADW);

            if (p_clrn && !dac_clrn) begin
                if (evq.size() == 0) chk(0, "R7", "clear pulse with no request", 1, 0);
                else begin
                    ev = evq.pop_front();
                    chk(ev[17] == 1'b1, "R9 R11", "event order: clear where frame expected", ev[17], 0);
                    chk(dac_clrsel == ev[16], "R7", "clear select", dac_clrsel, ev[16]);
                end
                clr_cnt = 0; sel_bad = 0; sel_ref = dac_clrsel;
            end
            if (!dac_clrn) begin
                clr_cnt++;
                if (dac_clrsel != sel_ref) sel_bad = 1;
            end
            if (!p_clrn && dac_clrn) begin
                chk(clr_cnt == CLRW, "R7", "clear pulse width", clr_cnt, CLRW);
                chk(!sel_bad, "R7", "clear select moved", sel_bad, 0);
            end

            p_sclk <= dac_sclk; p_csn <= dac_csn; p_ldn <= dac_ldn;
            p_clrn <= dac_clrn; p_sdi <= dac_sdi;
        end
    end

    task automatic send_cmd(logic [1:0] ch, logic [11:0] cd);
        @(posedge clk); #1;
        cmd_valid = 1'b1; cmd_chan = ch; cmd_code = cd;
        do @(negedge clk); while (!cmd_ready);
        @(posedge clk); #1;
        cmd_valid = 1'b0;
    endtask

    task automatic pulse_clr(logic sel);
        @(posedge clk); #1;
        clr_req = 1'b1; clr_mid = sel;
        @(posedge clk); #1;
        clr_req = 1'b0;
    endtask

    task automatic clr_and_cmd(logic sel, logic [1:0] ch, logic [11:0] cd);
        @(posedge clk); #1;
        clr_req = 1'b1; clr_mid = sel;
        cmd_valid = 1'b1; cmd_chan = ch; cmd_code = cd;
        @(posedge clk); #1;
        clr_req = 1'b0; cmd_valid = 1'b0;
    endtask

    task automatic wait_idle();
        do @(negedge clk); while (!(evq.size() == 0 && cmd_ready));
    endtask

    task automatic wait_frame();
        do @(negedge clk); while (dac_csn);
    endtask

    task automatic check_idle(string tag);
        chk(dac_sclk && dac_csn && dac_ldn && dac_clrn, tag, "idle line levels",
            {dac_sclk, dac_csn, dac_ldn, dac_clrn}, 4'hf);
        chk(cmd_ready, tag, "ready when idle", cmd_ready, 1);
    endtask

    initial begin
        repeat (5) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        check_idle("R10");
        chk(!dac_clrsel, "R10", "clear select after reset", dac_clrsel, 0);

        // R1 R3 R5 R8: directed frames, back to back
        send_cmd(2'd0, 12'h000);
        send_cmd(2'd3, 12'hfff);
        send_cmd(2'd1, 12'ha5a);
        send_cmd(2'd2, 12'h5a5);
        wait_idle();
        // R7: clears to midscale and zero
        pulse_clr(1'b1); wait_idle();
        pulse_clr(1'b0); wait_idle();
        // R9: clear and command together
        clr_and_cmd(1'b1, 2'd2, 12'h123); wait_idle();
        // R11: clear during a frame
        send_cmd(2'd1, 12'h800); wait_frame(); pulse_clr(1'b0); wait_idle();

        void'($urandom(32'd4242));
        for (int i = 0; i < 48; i++) begin
            int op;
            op = $urandom % 4;
            case (op)
                0: send_cmd(2'($urandom), 12'($urandom));
                1: begin wait_idle(); pulse_clr(1'($urandom)); end
                2: begin wait_idle(); clr_and_cmd(1'($urandom), 2'($urandom), 12'($urandom)); end
                default: begin
                    send_cmd(2'($urandom), 12'($urandom));
                    wait_frame();
                    repeat ($urandom % 20) @(posedge clk);
                    pulse_clr(1'($urandom));
                end
            endcase
            repeat ($urandom % 3) @(posedge clk);
        end

        wait_idle();
        repeat (LOADW + CLRW + 4) @(negedge clk);
        check_idle("R2");
        chk(evq.size() == 0, "R8", "events left unobserved", evq.size(), 0);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog R8 run did not finish actual=%0d expected=%0d", 1, 0);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule